// File: doc/BRIEF.md
# Non-Blocking Instruction Fetch Reorderer

The block sits between an instruction fetch port and the burst memory behind an instruction cache, and lets several line reads be outstanding at once. Every accepted request is logged in a circular reorder buffer in arrival order. A cache lookup result (`hit_i`, `hit_data_i`) arrives with the request. A hit is stored as finished at once. A miss is also placed in a first-in first-out issue queue, which offers one memory read at a time.

Each memory read carries a tag built from the buffer slot and that slot's epoch bit. Memory may return lines in any order. A return whose tag matches a slot that is still waiting writes the 256-bit line into that slot and marks it finished. Only the oldest slot may retire. It retires in the cycle after it becomes finished and presents its address and line to the fetch unit. At most one slot retires per clock.

A flush discards every buffered request and every queued read. Each slot flips its epoch bit whenever it is allocated, so a line that was still in flight before a flush cannot wake a later occupant of the same slot.

Top module: `ifetch_reorder`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_o` are 0.
- R2: Responses leave in exactly the order the requests were accepted, whatever order memory returns lines in. A finished entry behind an unfinished head stays invisible.
- R3: An accepted hit produces `rsp_valid_o` in the next cycle if it is the oldest entry. It carries the request address and `hit_data_i`, and it causes no memory read.
- R4: Accepted misses appear on `mem_req_o`/`mem_addr_o` in acceptance order. The address is held until a cycle with `mem_gnt_i` high. `mem_tag_o` is {epoch bit, slot index}, with the epoch in the MSB.
- R5: A return with `mem_rvalid_i` and a `mem_rtag_i` that matches a waiting slot stores `mem_rdata_i` in that slot. If that slot is oldest, it retires in the following cycle carrying that line.
- R6: `req_ready_o` is 0 while the reorder buffer holds ROB_DEPTH entries, while the issue queue holds IQ_DEPTH reads, or while `flush_i` is high. A request offered while ready is low is not taken.
- R7: `flush_i` empties both structures. In the next cycle `rsp_valid_o` and `mem_req_o` are 0 and `req_ready_o` is 1.
- R8: A return whose tag names an empty slot, a finished slot, or a slot whose epoch differs is ignored.
- R9: A retirement and a new acceptance may happen in the same cycle. The retiring slot frees capacity from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Discard all buffered and queued work |
| req_valid_i | input | 1 | Fetch request offered |
| req_addr_i | input | ADDR_W | Line address of the request |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| hit_i | input | 1 | Lookup hit for the offered request |
| hit_data_i | input | 256 | Line data on a hit |
| mem_req_o | output | 1 | Memory read offered |
| mem_addr_o | output | ADDR_W | Address of the offered read |
| mem_tag_o | output | IDX_W+1 | {epoch, slot} of the offered read |
| mem_gnt_i | input | 1 | Memory takes the offered read |
| mem_rvalid_i | input | 1 | Memory returns a line |
| mem_rtag_i | input | IDX_W+1 | Tag of the returned line |
| mem_rdata_i | input | 256 | Returned line |
| rsp_valid_o | output | 1 | Oldest entry retires this cycle |
| rsp_addr_o | output | ADDR_W | Address of the retiring entry |
| rsp_data_o | output | 256 | Line of the retiring entry |

## Verification
Retirement of the head, wakeup from a memory return, and acceptance of a new request can all land on one clock edge. The bench provokes this by holding the head on an unanswered miss with hits queued behind it, then releasing the line while offering a hit every cycle. Lines are also returned in reverse order. A behavioural queue model predicts, for every cycle, the ready level, the memory read, and whether and what retires, and the outputs are compared against it. Stale returns are injected after a flush into an empty slot and into a reallocated slot with the other epoch, and the model expects no wakeup from either.

// File: rtl/icr_pkg.sv
package icr_pkg;
  localparam int unsigned LINE_W = 256;
  typedef logic [LINE_W-1:0] line_t;
endpackage

// File: rtl/icr_issue_q.sv
module icr_issue_q import icr_pkg::*; #(
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TAG_W  = 3,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [TAG_W-1:0]  push_tag_i,
  output logic              full_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [TAG_W-1:0]  tag_o,
  input  logic              gnt_i
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [PTR_W-1:0]  rd_q, wr_q;
  logic [PTR_W:0]    cnt_q;
  logic              pop;

  assign full_o  = cnt_q == (PTR_W+1)'(DEPTH);
  assign valid_o = (cnt_q != '0) && !flush_i;
  assign addr_o  = addr_q[rd_q];
  assign tag_o   = tag_q[rd_q];
  assign pop     = valid_o && gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pop)    rd_q <= (rd_q == PTR_W'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      if (push_i) wr_q <= (wr_q == PTR_W'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      cnt_q <= cnt_q + (PTR_W+1)'(push_i) - (PTR_W+1)'(pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) begin
      addr_q[wr_q] <= push_addr_i;
      tag_q[wr_q]  <= push_tag_i;
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_hold_until_gnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !gnt_i |=> flush_i || (valid_o && $stable(addr_o) && $stable(tag_o)));
endmodule

// File: rtl/icr_rob.sv
module icr_rob import icr_pkg::*; #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              alloc_hit_i,
  input  line_t             alloc_data_i,
  output logic [IDX_W-1:0]  alloc_idx_o,
  output logic              alloc_epoch_o,
  output logic              full_o,
  input  logic              wake_i,
  input  logic [IDX_W-1:0]  wake_idx_i,
  input  logic              wake_epoch_i,
  input  line_t             wake_data_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output line_t             rsp_data_o
);
  logic [DEPTH-1:0]  vld_q, done_q, ep_q;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  line_t             data_q [DEPTH];
  logic [IDX_W-1:0]  head_q, tail_q;
  logic [IDX_W:0]    cnt_q;
  logic              retire, wake_ok;

  assign retire        = vld_q[head_q] && done_q[head_q];
  assign rsp_valid_o   = retire;
  assign rsp_addr_o    = addr_q[head_q];
  assign rsp_data_o    = data_q[head_q];
  assign full_o        = cnt_q == (IDX_W+1)'(DEPTH);
  assign alloc_idx_o   = tail_q;
  assign alloc_epoch_o = ~ep_q[tail_q];
  // stale or duplicate returns fall through here
  assign wake_ok = wake_i && vld_q[wake_idx_i] && !done_q[wake_idx_i]
                   && (ep_q[wake_idx_i] == wake_epoch_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      done_q <= '0;
      ep_q   <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (retire) begin
        vld_q[head_q] <= 1'b0;
        head_q <= (head_q == IDX_W'(DEPTH-1)) ? '0 : head_q + 1'b1;
      end
      if (wake_ok) done_q[wake_idx_i] <= 1'b1;
      if (alloc_i) begin
        vld_q[tail_q]  <= 1'b1;
        done_q[tail_q] <= alloc_hit_i;
        ep_q[tail_q]   <= ~ep_q[tail_q];
        tail_q <= (tail_q == IDX_W'(DEPTH-1)) ? '0 : tail_q + 1'b1;
      end
      cnt_q <= cnt_q + (IDX_W+1)'(alloc_i) - (IDX_W+1)'(retire);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!flush_i) begin
      if (alloc_i) begin
        addr_q[tail_q] <= alloc_addr_i;
        if (alloc_hit_i) data_q[tail_q] <= alloc_data_i;
      end
      if (wake_ok) data_q[wake_idx_i] <= wake_data_i;
    end
  end

  p_rob_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !full_o);
  p_flush_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !rsp_valid_o);
  p_hit_next_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i && alloc_hit_i && (cnt_q == '0) && !flush_i |=> rsp_valid_o);
  p_retire_frees_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !alloc_i && !flush_i |=> !full_o);
endmodule

// File: rtl/ifetch_reorder.sv
module ifetch_reorder import icr_pkg::*; #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned ROB_DEPTH = 4,
  parameter int unsigned IQ_DEPTH  = 2,
  localparam int unsigned IDX_W    = $clog2(ROB_DEPTH),
  localparam int unsigned TAG_W    = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  input  logic              hit_i,
  input  line_t             hit_data_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [TAG_W-1:0]  mem_tag_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [TAG_W-1:0]  mem_rtag_i,
  input  line_t             mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output line_t             rsp_data_o
);
  logic             rob_full, iq_full, accept, alloc_ep;
  logic [IDX_W-1:0] alloc_idx;

  assign req_ready_o = !rob_full && !iq_full && !flush_i;
  assign accept      = req_valid_i && req_ready_o;

  icr_rob #(.DEPTH(ROB_DEPTH), .ADDR_W(ADDR_W)) u_rob (
    .clk_i, .rst_ni, .flush_i,
    .alloc_i      (accept),
    .alloc_addr_i (req_addr_i),
    .alloc_hit_i  (hit_i),
    .alloc_data_i (hit_data_i),
    .alloc_idx_o  (alloc_idx),
    .alloc_epoch_o(alloc_ep),
    .full_o       (rob_full),
    .wake_i       (mem_rvalid_i),
    .wake_idx_i   (mem_rtag_i[IDX_W-1:0]),
    .wake_epoch_i (mem_rtag_i[IDX_W]),
    .wake_data_i  (mem_rdata_i),
    .rsp_valid_o, .rsp_addr_o, .rsp_data_o
  );

  icr_issue_q #(.DEPTH(IQ_DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_iq (
    .clk_i, .rst_ni, .flush_i,
    .push_i      (accept && !hit_i),
    .push_addr_i (req_addr_i),
    .push_tag_i  ({alloc_ep, alloc_idx}),
    .full_o      (iq_full),
    .valid_o     (mem_req_o),
    .addr_o      (mem_addr_o),
    .tag_o       (mem_tag_o),
    .gnt_i       (mem_gnt_i)
  );

  p_miss_issues_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !hit_i && !mem_req_o |=> flush_i || (mem_req_o && mem_addr_o == $past(req_addr_i)));
endmodule

// File: tb/ifetch_reorder_tb.sv
module ifetch_reorder_tb;
  import icr_pkg::*;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, rv = 0, hit = 0, gnt = 0, mrv = 0;
  logic [AW-1:0] raddr = '0;
  line_t hdata = '0, mdata = '0;
  logic [2:0] mrtag = '0;
  logic req_ready, mem_req, rsp_valid;
  logic [AW-1:0] mem_addr, rsp_addr;
  logic [2:0] mem_tag;
  line_t rsp_data;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  ifetch_reorder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .req_valid_i(rv), .req_addr_i(raddr), .req_ready_o(req_ready),
    .hit_i(hit), .hit_data_i(hdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_tag_o(mem_tag), .mem_gnt_i(gnt),
    .mem_rvalid_i(mrv), .mem_rtag_i(mrtag), .mem_rdata_i(mdata),
    .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr), .rsp_data_o(rsp_data));

  typedef struct {
    logic [AW-1:0] addr;
    bit hit, done, granted;
    line_t data;
    logic [2:0] tag;
  } ent_t;
  ent_t mq[$];
  logic [2:0] tag_log[$];
  logic [AW-1:0] addr_log[$];

  function automatic line_t mline(logic [AW-1:0] a); return {8{a ^ 32'h5a5a_0f0f}}; endfunction
  function automatic line_t hline(logic [AW-1:0] a); return {8{~a}}; endfunction

  task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int ungranted();
    int n = 0;
    foreach (mq[i]) if (!mq[i].hit && !mq[i].granted) n++;
    return n;
  endfunction

  // check outputs against model, advance model, step one clock
  task automatic tick();
    bit e_rdy, e_rv, e_mr;
    int first;
    #1;
    e_rdy = (mq.size() < 4) && (ungranted() < 2) && !flush;
    chk(req_ready == e_rdy, "R6 ready", 256'(req_ready), 256'(e_rdy));
    e_rv = (mq.size() > 0) && mq[0].done;
    chk(rsp_valid == e_rv, "R2 rsp_valid", 256'(rsp_valid), 256'(e_rv));
    if (e_rv && rsp_valid) begin
      chk(rsp_addr == mq[0].addr, mq[0].hit ? "R3 addr" : "R5 addr", 256'(rsp_addr), 256'(mq[0].addr));
      chk(rsp_data == mq[0].data, mq[0].hit ? "R3 data" : "R5 data", rsp_data, mq[0].data);
    end
    e_mr = (ungranted() > 0) && !flush;
    chk(mem_req == e_mr, "R4 mem_req", 256'(mem_req), 256'(e_mr));
    first = -1;
    foreach (mq[i]) if (first < 0 && !mq[i].hit && !mq[i].granted) first = i;
    if (e_mr && mem_req)
      chk(mem_addr == mq[first].addr, "R4 mem_addr", 256'(mem_addr), 256'(mq[first].addr));
    if (flush) mq.delete();
    else begin
      if (gnt && e_mr) begin
        mq[first].granted = 1;
        mq[first].tag = mem_tag;
        tag_log.push_back(mem_tag);
        addr_log.push_back(mq[first].addr);
      end
      if (e_rv) void'(mq.pop_front());
      if (mrv) foreach (mq[i])
        if (mq[i].granted && !mq[i].done && mq[i].tag == mrtag) begin
          mq[i].done = 1;
          mq[i].data = mdata;
        end
      if (rv && e_rdy) mq.push_back('{raddr, hit, hit, 1'b0, hit ? hdata : '0, 3'd0});
    end
    @(negedge clk);
    cyc++;
    rv = 0; hit = 0; gnt = 0; mrv = 0; flush = 0;
  endtask

  task automatic req(logic [AW-1:0] a, bit h);
    rv = 1; raddr = a; hit = h; hdata = hline(a);
  endtask
  task automatic ret(int k);
    mrv = 1; mrtag = tag_log[k]; mdata = mline(addr_log[k]);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    #1;
    chk(req_ready && !rsp_valid && !mem_req, "R1 reset state",
        256'({req_ready, rsp_valid, mem_req}), 256'(3'b100));
    @(negedge clk);

    // R3: lone hit
    req(32'h1000, 1); tick();
    #1; chk(!mem_req, "R3 no memory read", 256'(mem_req), 0);
    tick(); tick();

    // R2/R5: two misses, returned in reverse order
    req(32'h2000, 0); tick();
    req(32'h2040, 0); tick();
    #1; chk(!req_ready, "R6 issue queue full", 256'(req_ready), 0);
    gnt = 1; tick();
    gnt = 1; tick();
    k = tag_log.size();
    ret(k-1); tick();
    #1; chk(!rsp_valid, "R2 younger finished entry held", 256'(rsp_valid), 0);
    ret(k-2); tick();
    tick(); tick(); tick();

    // R6/R9: head blocked on a miss, hits fill the buffer, then drain while accepting
    req(32'h3000, 0); tick();
    req(32'h3100, 1); tick();
    req(32'h3200, 1); tick();
    req(32'h3300, 1); tick();
    #1; chk(!req_ready, "R6 reorder buffer full", 256'(req_ready), 0);
    req(32'h3400, 1); gnt = 1; tick();
    k = tag_log.size();
    ret(k-1); req(32'h3500, 1); tick();
    for (int i = 0; i < 6; i++) begin
      #1; if (rsp_valid && !req_ready) chk(1'b1, "R9 retire while full", 0, 0);
      req(32'h3600 + 32'(i) * 32'h40, 1); tick();
    end
    #1; chk(req_ready, "R9 capacity regained", 256'(req_ready), 1);
    repeat (6) tick();

    // R7: flush with a read in flight
    flush = 1; tick();
    req(32'h4000, 0); tick();
    gnt = 1; tick();
    k = tag_log.size();
    req(32'h4100, 1); flush = 1; tick();
    #1; chk(!rsp_valid && !mem_req && req_ready, "R7 empty after flush",
            256'({rsp_valid, mem_req, req_ready}), 256'(3'b001));
    ret(k-1); tick();
    #1; chk(!rsp_valid, "R8 return to empty slot dropped", 256'(rsp_valid), 0);

    // R8: slot reused with the other epoch, stale line must not wake it
    req(32'h5000, 0); tick();
    gnt = 1; tick();
    ret(k-1); tick();
    #1; chk(!rsp_valid, "R8 stale epoch dropped", 256'(rsp_valid), 0);
    #1; chk(tag_log[k-1][2] != tag_log[k][2], "R8 epoch flipped",
            256'(tag_log[k][2]), 256'(~tag_log[k-1][2]));
    ret(k); tick();
    tick(); tick();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule